// File: doc/BRIEF.md
# Scrambling NRZI Video Serializer

This block turns parallel video words into a single serial bit stream, one bit per bit-rate clock. A word is taken in whenever the load enable is high. It is then shifted out least significant bit first over the next ten clocks. In the normal encoding mode each bit goes through a self-synchronising scrambler with generator x^9 + x^4 + 1, and then through an NRZ-to-NRZI stage (x + 1). A receiver can therefore recover the data from transitions alone, with no word alignment needed for the descrambler.

A second mode turns the block into a plain 8/10-bit shift-out: the scrambler and the NRZI stage are bypassed, and their state is kept at zero. An 8-bit word is placed in the upper eight bits of the 10-bit word, and the lower two bits are filled with zeros. A flush strobe brings every piece of encoder state back to zero in one clock, so a new stream can start cleanly. Clock multiplication, line drivers and sync detection are outside this block.

Top module: `vid_serializer`

## Requirements
- R1: A word is captured on the rising edge at which `loadEn` is high and `flush` is low. `serOut` presents bit 0 after the next edge, then bits 1 to 9 on the edges that follow. This is a one-cycle register latency, least significant bit first.
- R2: With `loadEn` pulsed every 10 clocks, the words follow each other on `serOut` with no bit dropped, repeated or inserted. Between loads, zeros shift into the top of the shift register.
- R3: When `wide8` is 1 at load, the word sent is `{dataIn[7:0], 2'b00}` and `dataIn[9:8]` has no effect. When `wide8` is 0, all ten bits of `dataIn` are sent.
- R4: Encoding mode (`plainMode` 0 at load) works as follows. The scrambled bit is s[n] = d[n] ^ s[n-4] ^ s[n-9]. The output follows serOut[n] = serOut[n-1] ^ s[n], so a transition on `serOut` marks a scrambled 1. Starting from zero state, the stream descrambles back to the words sent.
- R5: Plain mode (`plainMode` 1 at load) sends each data bit unchanged on `serOut`. The scrambler and NRZI state are held at zero, so a later encoded word starts from zero history.
- R6: `plainMode` is sampled only together with a word load, and applies to every bit of that word. Changes between loads have no effect on the bits in flight.
- R7: `flush` high at a rising edge clears the shift register, scrambler, NRZI state and `serOut` to 0, and it wins over a simultaneous load. With no further load, `serOut` then stays 0.
- R8: While `rstN` is low, all state clears asynchronously: `serOut` is 0 and the mode latch selects encoding mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Capture `dataIn` on this edge |
| dataIn | input | 10 | Parallel word; 8-bit words use bits 7:0 |
| wide8 | input | 1 | 1 = 8-bit word, MSB-aligned with two zero LSBs |
| plainMode | input | 1 | 1 = plain shift-out, 0 = scrambled NRZI |
| flush | input | 1 | Synchronous clear of all encoder state |
| serOut | output | 1 | Serial output bit |

## Verification
Assertions check the following on every cycle:
- the load-or-shift step of the shift register;
- that the output transitions agree with the scrambled bit in encoding mode;
- that scrambler and NRZI state sit at zero in plain mode;
- that a flush leaves all state cleared;
- that the mode latch holds between loads.

Only the bench scenarios can show that whole words survive end to end. The bench descrambles the captured stream with the inverse polynomial across back-to-back words and mode switches. It also covers 8-bit placement with the upper input bits driven, mode toggling mid-word, and flush both mid-word and against a simultaneous load.

// File: rtl/vid_ser_pkg.sv
package vid_ser_pkg;
  localparam int WORD_W   = 10;
  localparam int NARROW_W = 8;
  localparam int LFSR_LEN = 9;
  localparam int LFSR_TAP = 4;

  typedef struct packed {
    logic load;   // capture a new word this edge
    logic clear;  // flush all encoder state
    logic plain;  // word in flight uses plain shift-out
  } serStrobes_t;
endpackage

// File: rtl/vid_ser_ctrl.sv
module vid_ser_ctrl
  import vid_ser_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic        flush,
  input  logic        plainMode,
  output serStrobes_t strobes
);
  logic wordPlain;
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordPlain <= 1'b0;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (loadEn && !flush) wordPlain <= plainMode;
    end
  end

  always_comb begin
    strobes.clear = flush;
    strobes.load  = loadEn & ~flush;
    strobes.plain = wordPlain;
  end

  // R6: mode only moves on an accepted load
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(loadEn && !flush) |-> $stable(wordPlain));

  // R6: an accepted load takes the sampled mode
  a_r6_mode_take: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(loadEn && !flush) |-> wordPlain == $past(plainMode));
endmodule

// File: rtl/vid_ser_path.sv
module vid_ser_path
  import vid_ser_pkg::*;
#(
  parameter int WIDTH  = WORD_W,
  parameter int NARROW = NARROW_W,
  parameter int SLEN   = LFSR_LEN,
  parameter int STAP   = LFSR_TAP
) (
  input  logic             clk,
  input  logic             rstN,
  input  serStrobes_t      strobes,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             wide8,
  output logic             serOut
);
  localparam int PAD_W = WIDTH - NARROW;

  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] wordIn;
  logic [SLEN-1:0]  lfsr;     // lfsr[k] holds s[n-1-k]
  logic             nrziQ;
  logic             outReg;
  logic             dataBit;
  logic             scrBit;
  logic             armed;

  generate
    if (PAD_W > 0) begin : g_pad
      assign wordIn = wide8 ? {dataIn[NARROW-1:0], {PAD_W{1'b0}}} : dataIn;
    end else begin : g_nopad
      assign wordIn = dataIn;
    end
  endgenerate

  assign dataBit = shiftReg[0];
  assign scrBit  = dataBit ^ lfsr[STAP-1] ^ lfsr[SLEN-1];
  assign serOut  = outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      lfsr     <= '0;
      nrziQ    <= 1'b0;
      outReg   <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (strobes.clear) begin
        shiftReg <= '0;
        lfsr     <= '0;
        nrziQ    <= 1'b0;
        outReg   <= 1'b0;
      end else begin
        shiftReg <= strobes.load ? wordIn : {1'b0, shiftReg[WIDTH-1:1]};
        if (strobes.plain) begin
          lfsr   <= '0;
          nrziQ  <= 1'b0;
          outReg <= dataBit;
        end else begin
          lfsr   <= {lfsr[SLEN-2:0], scrBit};
          nrziQ  <= nrziQ ^ scrBit;
          outReg <= nrziQ ^ scrBit;
        end
      end
    end
  end

  // R1: an accepted load lands the word in the shift register
  a_r1_load_word: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strobes.load && !strobes.clear) |-> shiftReg == $past(wordIn));

  // R2: without a load the register moves one place toward bit 0
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(!strobes.load && !strobes.clear)
    |-> shiftReg == {1'b0, $past(shiftReg[WIDTH-1:1])});

  // R4: in encoding mode the output toggles exactly on a scrambled one
  a_r4_nrzi_toggle: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(!strobes.plain && !strobes.clear)
    |-> (serOut ^ $past(nrziQ)) == $past(scrBit) && serOut == nrziQ);

  // R5: plain mode keeps encoder history at zero and passes data through
  a_r5_plain_state: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strobes.plain && !strobes.clear)
    |-> lfsr == '0 && !nrziQ && serOut == $past(dataBit));

  // R7: flush leaves every state element cleared
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strobes.clear)
    |-> shiftReg == '0 && lfsr == '0 && !nrziQ && !serOut);
endmodule

// File: rtl/vid_serializer.sv
module vid_serializer
  import vid_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              wide8,
  input  logic              plainMode,
  input  logic              flush,
  output logic              serOut
);
  serStrobes_t strobes;

  vid_ser_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .flush     (flush),
    .plainMode (plainMode),
    .strobes   (strobes)
  );

  vid_ser_path #(
    .WIDTH  (WORD_W),
    .NARROW (NARROW_W),
    .SLEN   (LFSR_LEN),
    .STAP   (LFSR_TAP)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .wide8   (wide8),
    .serOut  (serOut)
  );
endmodule

// File: tb/vid_serializer_tb.sv
module vid_serializer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [9:0] dataIn = '0;
  logic       wide8 = 1'b0;
  logic       plainMode = 1'b0;
  logic       flush = 1'b0;
  logic       serOut;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  // receiver model state
  logic       prevOut = 1'b0;
  logic [8:0] hist = '0;
  logic       haveCur = 1'b0;
  logic       curPlain = 1'b0;
  logic [9:0] curExp = '0;
  logic [9:0] rxWord = '0;
  int         bitIdx = 0;
  int         wordNo = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  vid_serializer u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .dataIn(dataIn),
    .wide8(wide8), .plainMode(plainMode), .flush(flush), .serOut(serOut)
  );

  // {plainMode, wide8, data[9:0]}
  localparam logic [11:0] VECS [16] = '{
    12'h000, 12'h3FF, 12'h001, 12'h200, 12'h155, 12'h2AA,
    12'h7C3, 12'h4FF, 12'h93C, 12'hB01, 12'hDA5, 12'hFFF,
    12'h3E7, 12'h80F, 12'h612, 12'h0C9
  };

  function automatic logic [9:0] expWord(input logic [9:0] d, input logic w8);
    return w8 ? {d[7:0], 2'b00} : d;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [9:0] act,
                       input logic [9:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    prevOut = 1'b0;
    hist    = '0;
    haveCur = 1'b0;
  endtask

  // take one sampled output bit for the word in flight (R4 / R5 decode)
  task automatic consumeBit(input logic b);
    logic s, d;
    if (!haveCur) begin
      check(b == 1'b0, "R7/R8 idle output", {9'b0, b}, 10'h000);
      return;
    end
    if (curPlain) begin
      d = b;
      hist = '0;
      prevOut = 1'b0;
    end else begin
      s = b ^ prevOut;
      d = s ^ hist[3] ^ hist[8];
      hist = {hist[7:0], s};
      prevOut = b;
    end
    rxWord[bitIdx] = d;
    bitIdx++;
    if (bitIdx == 10) begin
      check(rxWord == curExp,
            curPlain ? "R1/R2/R3/R5/R6 plain word" : "R1/R2/R3/R4/R6 encoded word",
            rxWord, curExp);
      haveCur = 1'b0;
      wordNo++;
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [9:0] d, input logic w8, input logic pm);
    loadEn = 1'b1; dataIn = d; wide8 = w8; plainMode = pm;
    cycle();
    consumeBit(serOut);       // last bit of previous word, or idle
    loadEn = 1'b0; dataIn = ~d; wide8 = ~w8;
    plainMode = ~pm;          // R6: mode change mid-word must not matter
    haveCur = 1'b1; curPlain = pm; curExp = expWord(d, w8); bitIdx = 0;
    for (int i = 0; i < 9; i++) begin
      cycle();
      consumeBit(serOut);
    end
  endtask

  task automatic drain();
    loadEn = 1'b0;
    cycle();
    consumeBit(serOut);
  endtask

  task automatic doFlush();
    flush = 1'b1;
    cycle();
    flush = 1'b0;
    resetModel();
    check(serOut == 1'b0, "R7 output after flush", {9'b0, serOut}, 10'h000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    check(serOut == 1'b0, "R8 output in reset", {9'b0, serOut}, 10'h000);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(serOut == 1'b0, "R8 output after reset", {9'b0, serOut}, 10'h000);

    // table walk: back-to-back words, every 10 clocks
    for (int v = 0; v < 16; v++)
      sendWord(VECS[v][9:0], VECS[v][10], VECS[v][11]);
    drain();

    // R7: flush in the middle of an encoded all-ones word
    doFlush();
    loadEn = 1'b1; dataIn = 10'h3FF; wide8 = 1'b0; plainMode = 1'b0;
    cycle();
    loadEn = 1'b0;
    for (int i = 0; i < 3; i++) cycle();
    doFlush();
    for (int i = 0; i < 4; i++) begin
      cycle();
      check(serOut == 1'b0, "R7 state cleared mid-word", {9'b0, serOut}, 10'h000);
    end

    // R7: flush wins over a simultaneous load
    loadEn = 1'b1; flush = 1'b1; dataIn = 10'h3FF; wide8 = 1'b0; plainMode = 1'b0;
    cycle();
    loadEn = 1'b0; flush = 1'b0;
    resetModel();
    for (int i = 0; i < 11; i++) begin
      cycle();
      check(serOut == 1'b0, "R7 flush priority over load", {9'b0, serOut}, 10'h000);
    end

    // after flush: plain then encoded, zero history carried across (R5, R4)
    sendWord(10'h2C7, 1'b0, 1'b1);
    sendWord(10'h0F3, 1'b0, 1'b0);
    sendWord(10'h3A5, 1'b1, 1'b0);
    sendWord(10'h1FF, 1'b0, 1'b0);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule